// File: doc/BRIEF.md
# Selectable Rate Acquisition Scan Timer

This block paces an A/D acquisition sequence. It generates a conversion strobe that lasts one clock cycle and repeats at one of three selectable scan rates, all derived from a fixed system clock. Software controls it through single writes to an 8-bit control register. Bit 0 of a write is the run bit. Bits 3:2 carry a rate code that the block latches only from the write that starts acquisition.

Once acquisition runs, the block ignores later start writes completely. They neither change the latched rate nor restart the period counter. Only a write with the run bit clear is honoured, and it stops pulse generation. Two status outputs report whether acquisition is active and which rate is currently latched. With the default 10 MHz clock the three periods are 100, 200 and 400 cycles.

Top module: `scan_pacer`

## Requirements
- R1: After reset `scan_busy` is 0, `scan_pulse` is 0 and `rate_sel` is 0 (the fast rate).
- R2: A start write while idle (bit 0 = 1) with rate code 00 selects a period of 100 clock cycles (100 kHz at 10 MHz) and sets `rate_sel` to 0.
- R3: A start write with rate code 01 selects a period of 200 clock cycles (50 kHz) and sets `rate_sel` to 1.
- R4: A start write with rate code 10 selects a period of 400 clock cycles (25 kHz) and sets `rate_sel` to 2.
- R5: Rate code 11 behaves exactly like 01: the period is 200 cycles and `rate_sel` is 1.
- R6: Every scan pulse is high for exactly one clock cycle.
- R7: The first pulse appears N rising edges after the edge that captured the start write, where N is the selected period. Later pulses follow every N edges.
- R8: While acquisition is active, a write with bit 0 set has no effect. The rate, the counter phase and `rate_sel` stay unchanged. While idle, a write with bit 0 clear leaves `rate_sel` unchanged.
- R9: A write with bit 0 clear while active stops acquisition. `scan_busy` and `scan_pulse` are 0 from the next edge on, and no pulse occurs while idle.
- R10: `rate_sel` reports the latched rate as 0, 1 or 2 and never shows 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 8 | Write data: bit 0 run, bits 3:2 rate code |
| scan_pulse | output | 1 | One-cycle conversion strobe |
| scan_busy | output | 1 | Acquisition active |
| rate_sel | output | 2 | Latched rate: 0 fast, 1 middle, 2 slow |

## Verification
The bench aims at the alias code 11. A design that decoded this code as its own rate would run a 400-cycle or undefined period where 200 is expected. Start writes issued in the middle of a run are also targeted: a design that relatched on them would change period or restart its phase, which the cycle-exact pulse comparison catches. The exact edge of the first pulse exposes off-by-one counters. Stop writes that land next to a terminal count expose a stray pulse after stopping. A long random phase with sparse random writes mixes all of these against a bench-side timing model.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int CTRL_W    = 8;
  localparam int RUN_BIT   = 0;
  localparam int RATE_LSB  = 2;
  localparam int RATE_W    = 2;

  typedef enum logic [1:0] {
    RATE_FAST = 2'd0,
    RATE_MID  = 2'd1,
    RATE_SLOW = 2'd2
  } rate_e;

  function automatic rate_e decode_rate(input logic [RATE_W-1:0] code);
    case (code)
      2'b00:   decode_rate = RATE_FAST;
      2'b01:   decode_rate = RATE_MID;
      2'b10:   decode_rate = RATE_SLOW;
      default: decode_rate = RATE_MID;
    endcase
  endfunction
endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/scan_ctrl_decode.sv
module scan_ctrl_decode
  import scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [CTRL_W-1:0] ctl_data,
  output logic              start_evt,
  output logic              stop_evt,
  output logic              busy,
  output rate_e             rate
);
  logic  busy_q, busy_d;
  rate_e rate_q, rate_d;
  logic  rate_en;

  always_comb begin
    start_evt = ctl_wr &  ctl_data[RUN_BIT] & ~busy_q;
    stop_evt  = ctl_wr & ~ctl_data[RUN_BIT] &  busy_q;
    rate_en   = start_evt;
    busy_d    = busy_q;
    if (start_evt)     busy_d = 1'b1;
    else if (stop_evt) busy_d = 1'b0;
    rate_d = decode_rate(ctl_data[RATE_LSB +: RATE_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rate_q <= RATE_FAST;
    end else begin
      busy_q <= busy_d;
      if (rate_en) rate_q <= rate_d;
    end
  end

  assign busy = busy_q;
  assign rate = rate_q;

  // R8: rate holds while acquisition runs
  a_r8_rate_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (!busy_q || $stable(rate_q)));
  // R10: no fourth rate value
  a_r10_rate_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rate_q != 2'b11);
  // R9: stop always clears busy
  a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !busy_q);
endmodule

// File: rtl/scan_rate_divider.sv
module scan_rate_divider #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [CNT_W-1:0] period,
  output logic             pulse
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;
  logic             wrap;

  always_comb begin
    wrap    = (cnt_q == period - 1'b1);
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (run) begin
      pulse_d = wrap;
      cnt_d   = wrap ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

  // R6: strobe is one cycle wide
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  // R7: counter never passes the period
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < period);
endmodule

// File: rtl/scan_pacer.sv
module scan_pacer
  import scan_pkg::*;
#(
  parameter int CLK_HZ       = 10_000_000,
  parameter int FAST_RATE_HZ = 100_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [CTRL_W-1:0] ctl_data,
  output logic              scan_pulse,
  output logic              scan_busy,
  output logic [1:0]        rate_sel
);
  localparam int BASE_DIV = CLK_HZ / FAST_RATE_HZ;
  localparam int MAX_DIV  = BASE_DIV * 4;
  localparam int CNT_W    = $clog2(MAX_DIV + 1);

  logic             rst_n_s;
  logic             start_evt, stop_evt, busy;
  rate_e            rate;
  logic [CNT_W-1:0] period;

  scan_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  scan_ctrl_decode u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .start_evt(start_evt), .stop_evt(stop_evt), .busy(busy), .rate(rate)
  );

  always_comb begin
    case (rate)
      RATE_MID:  period = CNT_W'(BASE_DIV * 2);
      RATE_SLOW: period = CNT_W'(BASE_DIV * 4);
      default:   period = CNT_W'(BASE_DIV);
    endcase
  end

  scan_rate_divider #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n_s), .run(busy), .clr(start_evt | stop_evt),
    .period(period), .pulse(scan_pulse)
  );

  assign scan_busy = busy;
  assign rate_sel  = rate;

  // R9: no strobe while idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    !scan_busy |-> !scan_pulse);
  // R7: the first edge after start carries no strobe
  a_r7_no_early: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(scan_busy) |-> !scan_pulse);
endmodule

// File: tb/scan_pacer_bench.sv
module scan_pacer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_wr;
  logic [7:0] ctl_data;
  logic       scan_pulse, scan_busy;
  logic [1:0] rate_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  bit       m_busy, m_pulse;
  int       m_cnt;
  int       m_sel;

  always #10 clk = ~clk;

  scan_pacer u_scan_pacer (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .scan_pulse(scan_pulse), .scan_busy(scan_busy), .rate_sel(rate_sel)
  );

  function automatic int sel_of(input logic [1:0] code);
    case (code)
      2'b00: return 0;
      2'b10: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int period_of(input int sel);
    return 100 << sel;
  endfunction

  task automatic check(input string tag);
    n_chk++;
    if (scan_pulse !== m_pulse || scan_busy !== m_busy || rate_sel !== 2'(m_sel)) begin
      n_bad++;
      $display("FAIL %s: pulse=%0b busy=%0b rate=%0d expected pulse=%0b busy=%0b rate=%0d",
               tag, scan_pulse, scan_busy, rate_sel, m_pulse, m_busy, m_sel);
    end
  endtask

  task automatic step(input bit w, input logic [7:0] d, input string tag);
    ctl_wr   = w;
    ctl_data = d;
    @(negedge clk);
    ctl_wr = 1'b0;
    if (w && m_busy && !d[0]) begin
      m_busy = 0; m_cnt = 0; m_pulse = 0;
    end else if (w && !m_busy && d[0]) begin
      m_busy = 1; m_sel = sel_of(d[3:2]); m_cnt = 0; m_pulse = 0;
    end else if (m_busy) begin
      m_pulse = (m_cnt == period_of(m_sel) - 1);
      m_cnt   = m_pulse ? 0 : m_cnt + 1;
    end else begin
      m_pulse = 0;
    end
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_data = 8'h00;
    m_busy = 0; m_pulse = 0; m_cnt = 0; m_sel = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset state");

    step(1'b1, 8'h01, "R2 start fast");
    idle(250, "R2 R7 fast period");
    step(1'b1, 8'h00, "R9 stop");
    idle(40, "R9 idle quiet");

    step(1'b1, 8'h05, "R3 start mid");
    idle(450, "R3 R7 mid period");
    step(1'b1, 8'h00, "R9 stop mid");
    step(1'b1, 8'h08, "R8 idle rate write ignored");
    idle(10, "R10 rate held idle");

    step(1'b1, 8'h09, "R4 start slow");
    idle(850, "R4 R6 slow period");
    step(1'b1, 8'h00, "R9 stop slow");

    step(1'b1, 8'h0D, "R5 start alias");
    idle(150, "R5 alias period");
    step(1'b1, 8'h09, "R8 restart ignored");
    idle(60, "R8 phase kept");
    step(1'b1, 8'h01, "R8 fast ignored");
    idle(300, "R8 R5 rate kept");

    // stop right at a terminal count
    idle(period_of(m_sel) - 1 - m_cnt, "R7 run to edge");
    step(1'b1, 8'h00, "R9 stop at wrap");
    idle(20, "R9 no stray pulse");

    for (int i = 0; i < 30000; i++) begin
      if ($urandom_range(199) == 0)
        step(1'b1, 8'($urandom), "R6 random write");
      else
        step(1'b0, 8'h00, "R6 random run");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule